// File: doc/BRIEF.md
# Adaptive Half-Bridge Gate Interlock

This block sits between a PWM source and the two gate drivers of one half-bridge leg. It takes a high-side and a low-side command and produces two gate-enable outputs. The two switches are never on together. Dead time does not come from a fixed delay. Before a gate is enabled, the block needs a discharged indication from the gate feedback of the opposite switch, so the gap adapts to the real turn-off speed of each device.

Each supply has its own lockout with hysteresis. The main supply has one, and the bootstrapped high-side supply has one. Each lockout is fed by a pair of comparator flags: one says the supply has risen high enough, the other says it has fallen too low. A main-supply lockout blocks both gates and is reported on a status pin. A high-side supply lockout blocks only the high-side gate. If a feedback input never confirms discharge, a watchdog timer sets a sticky fault that holds the leg off until reset. All command, feedback and supply flags are synchronised inside the block. The gate outputs come straight from flops.

Top module: `hb_gate_interlock`

## Requirements
- R1: While reset is active and directly after it, both gate outputs are 0, `fault_o` is 0 and `uv_o` is 1. The main supply counts as locked out until its rise flag has been seen.
- R2: Main-supply lockout has hysteresis. `vmain_low_i`=1 sets the lockout, and this input wins over `vmain_ok_i`. `vmain_ok_i`=1 with `vmain_low_i`=0 clears it. While both flags are 0 the previous lockout state is kept. `uv_o` reports the lockout state.
- R3: Commands are non-inverting. Top command alone turns on `gate_top_o`, and bottom command alone turns on `gate_bot_o`, once the opposite feedback reports discharged.
- R4: When both commands are 1, both gate outputs are driven to 0.
- R5: `gate_top_o` and `gate_bot_o` are never 1 in the same cycle.
- R6: The high gate rises only after the synchronised low-side feedback (`fb_bot_off_i`, 1 = discharged) reads 1. The low gate rises only after the synchronised high-side feedback (`fb_top_off_i`) reads 1. While the opposite feedback reads 0, the requested gate stays off.
- R7: While the main supply is locked out, both gates are 0 whatever the commands are.
- R8: While the high-side supply is locked out (`vfloat_low_i`=1 sets it, `vfloat_ok_i`=1 clears it, same hysteresis as R2), only `gate_top_o` is held at 0. `gate_bot_o` follows its command.
- R9: If a wait for feedback lasts `TMO_CYC` cycles without confirmation, `fault_o` goes to 1 and stays 1 until reset. While it is set, both gates stay 0.
- R10: With feedback already confirmed and the leg idle, a command edge reaches its gate on the (`SYNC_STAGES`+1)-th rising clock edge after the input changes.
- R11: A command that changes during a turn-off wait is acted on only after that wait ends. A gate that is re-requested stays off until its own feedback reports discharged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_top_i | input | 1 | High-side switch command |
| cmd_bot_i | input | 1 | Low-side switch command |
| fb_top_off_i | input | 1 | High-side gate discharged (1 = below off level) |
| fb_bot_off_i | input | 1 | Low-side gate discharged (1 = below off level) |
| vmain_ok_i | input | 1 | Main supply above its start-up level |
| vmain_low_i | input | 1 | Main supply below its shutdown level |
| vfloat_ok_i | input | 1 | High-side supply above its start-up level |
| vfloat_low_i | input | 1 | High-side supply below its shutdown level |
| gate_top_o | output | 1 | High-side gate enable |
| gate_bot_o | output | 1 | Low-side gate enable |
| uv_o | output | 1 | Main supply lockout status |
| fault_o | output | 1 | Sticky feedback timeout fault |

## Verification
The hardest situations to reach are the ones where a command arrives while the block is still waiting for slow feedback, and the one where feedback never arrives. From the ports alone, such a gap is too short to observe. The bench therefore models each gate's discharge with a delay it can set: it lengthens the delay to hold the block inside a wait state while commands change, and it pins one feedback at 0 to drive the watchdog into its sticky fault.

// File: rtl/hbgi_pkg.sv
package hbgi_pkg;
   typedef enum logic [2:0] {
      ST_OFF          = 3'd0,
      ST_TOP_ON       = 3'd1,
      ST_BOT_ON       = 3'd2,
      ST_WAIT_TOP_OFF = 3'd3,
      ST_WAIT_BOT_OFF = 3'd4
   } leg_state_e;
endpackage

// File: rtl/hbgi_sync.sv
module hbgi_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbgi_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hbgi_uvlo.sv
module hbgi_uvlo (
   input  logic clk,
   input  logic rst_n,
   input  logic ok_i,
   input  logic low_i,
   output logic lock_o
);
   logic lock_q;

   // Shutdown flag dominates; with both flags idle the latch keeps its state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lock_q <= 1'b1;
      else if (low_i) lock_q <= 1'b1;
      else if (ok_i)  lock_q <= 1'b0;
   end

   assign lock_o = lock_q;
endmodule

// File: rtl/hbgi_fsm.sv
module hbgi_fsm
   import hbgi_pkg::*;
#(
   parameter int TMO_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_top,
   input  logic cmd_bot,
   input  logic fb_top_off,
   input  logic fb_bot_off,
   input  logic main_lock,
   input  logic flt_lock,
   output logic gate_top,
   output logic gate_bot,
   output logic fault
);
   localparam int CNT_W = $clog2(TMO_CYC + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO_CYC - 1);

   leg_state_e state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic fault_q, fault_d;
   logic gate_top_q, gate_bot_q;
   logic want_top, want_bot;

   assign want_top = cmd_top & ~cmd_bot & ~main_lock & ~flt_lock & ~fault_q;
   assign want_bot = cmd_bot & ~cmd_top & ~main_lock & ~fault_q;

   always_comb begin
      state_d = state_q;
      fault_d = fault_q;
      cnt_d   = '0;
      case (state_q)
         ST_OFF: begin
            if (want_top)      state_d = fb_bot_off ? ST_TOP_ON : ST_WAIT_BOT_OFF;
            else if (want_bot) state_d = fb_top_off ? ST_BOT_ON : ST_WAIT_TOP_OFF;
         end
         ST_TOP_ON: if (!want_top) state_d = ST_WAIT_TOP_OFF;
         ST_BOT_ON: if (!want_bot) state_d = ST_WAIT_BOT_OFF;
         ST_WAIT_TOP_OFF: begin
            if (fb_top_off) state_d = ST_OFF;
            else if (cnt_q == LIMIT) begin
               fault_d = 1'b1;
               state_d = ST_OFF;
            end else cnt_d = cnt_q + 1'b1;
         end
         ST_WAIT_BOT_OFF: begin
            if (fb_bot_off) state_d = ST_OFF;
            else if (cnt_q == LIMIT) begin
               fault_d = 1'b1;
               state_d = ST_OFF;
            end else cnt_d = cnt_q + 1'b1;
         end
         default: state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_OFF;
         cnt_q      <= '0;
         fault_q    <= 1'b0;
         gate_top_q <= 1'b0;
         gate_bot_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         cnt_q      <= cnt_d;
         fault_q    <= fault_d;
         gate_top_q <= (state_d == ST_TOP_ON);
         gate_bot_q <= (state_d == ST_BOT_ON);
      end
   end

   assign gate_top = gate_top_q;
   assign gate_bot = gate_bot_q;
   assign fault    = fault_q;
endmodule

// File: rtl/hb_gate_interlock.sv
module hb_gate_interlock #(
   parameter int SYNC_STAGES = 2,
   parameter int TMO_CYC     = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_top_i,
   input  logic cmd_bot_i,
   input  logic fb_top_off_i,
   input  logic fb_bot_off_i,
   input  logic vmain_ok_i,
   input  logic vmain_low_i,
   input  logic vfloat_ok_i,
   input  logic vfloat_low_i,
   output logic gate_top_o,
   output logic gate_bot_o,
   output logic uv_o,
   output logic fault_o
);
   localparam int N_IN  = 8;
   localparam int N_SUP = 2;

   if (TMO_CYC < 2) begin : g_bad_tmo
      $error("hb_gate_interlock: TMO_CYC must be at least 2");
   end

   logic [N_IN-1:0] raw_in, syn_in;
   logic s_cmd_top, s_cmd_bot, s_fb_top_off, s_fb_bot_off;
   logic [N_SUP-1:0] sup_ok, sup_low, sup_lock;
   logic main_lock, flt_lock;

   assign raw_in = {vfloat_low_i, vfloat_ok_i, vmain_low_i, vmain_ok_i,
                    fb_bot_off_i, fb_top_off_i, cmd_bot_i, cmd_top_i};

   hbgi_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
   );

   assign s_cmd_top    = syn_in[0];
   assign s_cmd_bot    = syn_in[1];
   assign s_fb_top_off = syn_in[2];
   assign s_fb_bot_off = syn_in[3];
   assign sup_ok       = {syn_in[6], syn_in[4]};
   assign sup_low      = {syn_in[7], syn_in[5]};

   for (genvar ch = 0; ch < N_SUP; ch++) begin : g_uvlo
      hbgi_uvlo u_uvlo (
         .clk(clk), .rst_n(rst_n),
         .ok_i(sup_ok[ch]), .low_i(sup_low[ch]), .lock_o(sup_lock[ch])
      );
   end

   assign main_lock = sup_lock[0];
   assign flt_lock  = sup_lock[1];

   hbgi_fsm #(.TMO_CYC(TMO_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .cmd_top(s_cmd_top), .cmd_bot(s_cmd_bot),
      .fb_top_off(s_fb_top_off), .fb_bot_off(s_fb_bot_off),
      .main_lock(main_lock), .flt_lock(flt_lock),
      .gate_top(gate_top_o), .gate_bot(gate_bot_o), .fault(fault_o)
   );

   assign uv_o = main_lock;
endmodule

// File: rtl/hbgi_chk.sv
module hbgi_chk (
   input logic clk,
   input logic rst_n,
   input logic gate_top,
   input logic gate_bot,
   input logic uv,
   input logic fault,
   input logic s_cmd_top,
   input logic s_cmd_bot,
   input logic s_fb_top,
   input logic s_fb_bot,
   input logic flt_lock
);
   a_r5_never_both_on: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_top && gate_bot));

   a_r6_top_after_bot_fb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_top) |-> $past(s_fb_bot));

   a_r6_bot_after_top_fb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_bot) |-> $past(s_fb_top));

   a_r4_both_cmd_off: assert property (@(posedge clk) disable iff (!rst_n)
      $past(s_cmd_top && s_cmd_bot) |-> (!gate_top && !gate_bot));

   a_r7_uv_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
      $past(uv) |-> (!gate_top && !gate_bot));

   a_r8_float_blocks_top: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flt_lock) |-> !gate_top);

   a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> fault);

   a_r9_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!gate_top && !gate_bot));
endmodule

bind hb_gate_interlock hbgi_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .gate_top(gate_top_o), .gate_bot(gate_bot_o),
   .uv(uv_o), .fault(fault_o),
   .s_cmd_top(s_cmd_top), .s_cmd_bot(s_cmd_bot),
   .s_fb_top(s_fb_top_off), .s_fb_bot(s_fb_bot_off),
   .flt_lock(flt_lock)
);

// File: tb/hb_gate_interlock_test.sv
`timescale 1ns/1ps
module hb_gate_interlock_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_top = 0, cmd_bot = 0;
   logic fb_top = 0, fb_bot = 0;
   logic vm_ok = 0, vm_low = 0, vf_ok = 0, vf_low = 0;
   logic gate_top, gate_bot, uv, fault;

   int checks = 0;
   int errors = 0;
   int overlap = 0;
   int top_dly = 3, bot_dly = 3;
   int top_cnt = 0, bot_cnt = 0;
   logic top_stuck = 0;

   typedef struct {
      logic  g_top;
      logic  g_bot;
      logic  uv;
      logic  flt;
      string tag;
   } exp_t;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   hb_gate_interlock uut (
      .clk(clk), .rst_n(rst_n),
      .cmd_top_i(cmd_top), .cmd_bot_i(cmd_bot),
      .fb_top_off_i(fb_top), .fb_bot_off_i(fb_bot),
      .vmain_ok_i(vm_ok), .vmain_low_i(vm_low),
      .vfloat_ok_i(vf_ok), .vfloat_low_i(vf_low),
      .gate_top_o(gate_top), .gate_bot_o(gate_bot),
      .uv_o(uv), .fault_o(fault)
   );

   // Gate discharge model: feedback reads 1 a set number of cycles after the gate drops.
   always @(negedge clk) begin
      if (gate_top) begin top_cnt = 0; fb_top = 0; end
      else if (top_cnt < top_dly) begin top_cnt++; fb_top = 0; end
      else fb_top = !top_stuck;
      if (gate_bot) begin bot_cnt = 0; fb_bot = 0; end
      else if (bot_cnt < bot_dly) begin bot_cnt++; fb_bot = 0; end
      else fb_bot = 1;
      if (gate_top && gate_bot) overlap++;
   end

   // Scoreboard monitor
   initial forever begin
      @(negedge clk);
      #0.2;
      while (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (gate_top !== e.g_top || gate_bot !== e.g_bot || uv !== e.uv || fault !== e.flt) begin
            errors++;
            $display("FAIL %s: actual top=%b bot=%b uv=%b fault=%b expected top=%b bot=%b uv=%b fault=%b",
                     e.tag, gate_top, gate_bot, uv, fault, e.g_top, e.g_bot, e.uv, e.flt);
         end
      end
   end

   task automatic expect_after(input int n, input logic t, input logic b,
                               input logic u, input logic f, input string tag);
      exp_t e;
      repeat (n) @(negedge clk);
      #0.1;
      e.g_top = t; e.g_bot = b; e.uv = u; e.flt = f; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic drive_cmd(input logic t, input logic b);
      @(negedge clk);
      cmd_top = t;
      cmd_bot = b;
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      expect_after(3, 0, 0, 1, 0, "R1 in reset");
      @(negedge clk); rst_n = 1;
      expect_after(4, 0, 0, 1, 0, "R1 after reset");

      // R2 hysteresis on the main supply
      @(negedge clk); vm_ok = 1; vf_ok = 1;
      expect_after(10, 0, 0, 0, 0, "R2 rise clears lock");
      @(negedge clk); vm_ok = 0;
      expect_after(10, 0, 0, 0, 0, "R2 hold unlocked");
      @(negedge clk); vm_low = 1;
      expect_after(10, 0, 0, 1, 0, "R2 fall sets lock");
      @(negedge clk); vm_low = 0;
      expect_after(10, 0, 0, 1, 0, "R2 hold locked");
      @(negedge clk); vm_ok = 1;
      expect_after(10, 0, 0, 0, 0, "R2 unlock again");

      // R10 latency, R3 top
      drive_cmd(1, 0);
      expect_after(2, 0, 0, 0, 0, "R10 not yet");
      expect_after(1, 1, 0, 0, 0, "R10 R3 top on edge 3");

      // R3 bottom
      drive_cmd(0, 1);
      expect_after(15, 0, 1, 0, 0, "R3 bottom on");

      // R4 both high
      drive_cmd(1, 1);
      expect_after(15, 0, 0, 0, 0, "R4 both commands");
      drive_cmd(1, 0);
      expect_after(15, 1, 0, 0, 0, "R3 top after both");

      // R6 slow high-side discharge delays bottom turn-on
      top_dly = 20;
      drive_cmd(0, 1);
      expect_after(15, 0, 0, 0, 0, "R6 bottom waits for top feedback");
      expect_after(20, 0, 1, 0, 0, "R6 bottom after feedback");
      top_dly = 3;

      // R11 command flips during wait
      bot_dly = 20;
      drive_cmd(0, 0);
      repeat (5) @(negedge clk);
      cmd_top = 1;
      expect_after(8, 0, 0, 0, 0, "R11 re-request held in wait");
      expect_after(30, 1, 0, 0, 0, "R11 served after wait");
      bot_dly = 3;

      // R7 main lockout
      @(negedge clk); vm_low = 1;
      expect_after(10, 0, 0, 1, 0, "R7 top forced off");
      drive_cmd(0, 1);
      expect_after(15, 0, 0, 1, 0, "R7 bottom forced off");
      @(negedge clk); vm_low = 0;
      expect_after(15, 0, 1, 0, 0, "R7 R2 release lock");

      // R8 floating supply lockout
      @(negedge clk); vf_low = 1;
      expect_after(10, 0, 1, 0, 0, "R8 bottom unaffected");
      drive_cmd(1, 0);
      expect_after(20, 0, 0, 0, 0, "R8 top blocked");
      @(negedge clk); vf_low = 0;
      expect_after(15, 1, 0, 0, 0, "R8 top after release");

      // R9 stuck feedback
      top_stuck = 1;
      drive_cmd(0, 1);
      expect_after(100, 0, 0, 0, 1, "R9 timeout fault");
      top_stuck = 0;
      expect_after(20, 0, 0, 0, 1, "R9 fault sticky bottom");
      drive_cmd(1, 0);
      expect_after(20, 0, 0, 0, 1, "R9 fault sticky top");
      @(negedge clk); rst_n = 0;
      expect_after(2, 0, 0, 1, 0, "R1 R9 reset clears fault");
      @(negedge clk); rst_n = 1;
      expect_after(12, 1, 0, 0, 0, "R9 operation after reset");

      repeat (3) @(negedge clk);
      checks++;
      if (overlap != 0) begin
         errors++;
         $display("FAIL R5 overlap: actual=%0d expected=0", overlap);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule